// File: doc/BRIEF.md
# Bus-Cycle Break Condition Comparator

This block is a single channel of a hardware breakpoint unit. It observes every completed bus cycle on a monitor port and compares the cycle against a programmed condition. The condition has five parts: an address compare in which each address bit can be left out, the bus master class (CPU or DMA engine), the access kind (instruction fetch or data), the direction (read or write) and the operand size. A cycle raises the break only when all five parts hold at once.

A match sets a sticky flag. The interrupt request output follows that flag, and it stays asserted until software writes 1 to the flag bit. Software programs the channel through a small register port. The port holds a reference address, an address mask, a 16-bit cycle-condition register and a status register. A cleared cycle-condition register turns the channel off, and reset clears it.

Top module: `bus_break_channel`

## Requirements
- R1: Reset clears the reference address register (offset 0) and the mask register (offset 1). Both registers are ADDR_W bits wide, and every bit reads back exactly as it was written.
- R2: The cycle-condition register (offset 2) resets to 0. Only its bits 7:0 are stored. Bits 15:8 and every bit above them read 0, and writes to those bits have no effect.
- R3: A mask bit of 1 removes the matching address bit from the compare. A mask bit of 0 requires bus_addr to equal the reference address at that bit.
- R4: Condition bits 7:6 select the bus master class. 00 never breaks, 01 matches CPU cycles only (bus_is_dma=0), 10 matches DMA cycles only (bus_is_dma=1), and 11 matches either master.
- R5: Condition bits 5:4 select the access kind. 00 never matches, 01 matches fetch (bus_is_data=0), 10 matches data (bus_is_data=1), and 11 matches either.
- R6: Condition bits 3:2 select the direction. 00 never matches, 01 matches read (bus_is_write=0), 10 matches write (bus_is_write=1), and 11 matches either.
- R7: Condition bits 1:0 select the size. 00 matches any size. 01, 10 and 11 match only a bus_size of the same value, where 01 is byte, 10 is word and 11 is longword.
- R8: A cycle is compared only while bus_valid is 1, and a break needs all five condition parts to hold in that same cycle.
- R9: A matching cycle sets the status flag (offset 3, bit 0), and break_irq is high from the next clock edge onward. The flag stays set until software writes 1 to bit 0 of offset 3. If a match happens in the same cycle as that write, the flag stays set.
- R10: A register write in the same cycle as a monitored bus cycle does not affect that cycle, which is compared against the old values. The new values apply from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Register offset for write and read |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Read data of the selected register (combinational) |
| bus_valid | input | 1 | A monitored bus cycle completes this clock |
| bus_addr | input | ADDR_W | Address of the monitored cycle |
| bus_is_dma | input | 1 | 1 means the master is a DMA engine, 0 means the CPU |
| bus_is_data | input | 1 | 1 means a data access, 0 means an instruction fetch |
| bus_is_write | input | 1 | 1 means a write, 0 means a read |
| bus_size | input | 2 | Operand size code: 01 byte, 10 word, 11 longword |
| break_irq | output | 1 | Break interrupt request |

## Verification
The bench builds the block with its default ADDR_W of 32. At that width the top address bit is reachable, so a mismatch at bit 31 shows whether the mask is honoured across the full word. The behavioural model in the bench runs every field value of the master, kind, direction and size codes against cycles that agree and disagree with them. It also checks three same-edge cases: a register write that lands during a monitored cycle, a flag clear that meets a new match, and a disabled channel that meets a cycle whose address matches.

// File: rtl/brk_pkg.sv
// Package: shared constants and types for the break-condition channel.
// Assumes register offsets are two bits wide and that the condition
// register packs four two-bit fields into bits 7:0.
package brk_pkg;
    localparam int REG_SEL_W = 2;

    localparam logic [REG_SEL_W-1:0] SEL_ADDR   = 2'd0;
    localparam logic [REG_SEL_W-1:0] SEL_MASK   = 2'd1;
    localparam logic [REG_SEL_W-1:0] SEL_COND   = 2'd2;
    localparam logic [REG_SEL_W-1:0] SEL_STATUS = 2'd3;

    localparam int COND_W = 8;

    // Attributes of one monitored bus cycle.
    typedef struct packed {
        logic       is_dma;
        logic       is_data;
        logic       is_write;
        logic [1:0] size;
    } bus_attr_t;

    // Decoded view of the stored condition byte.
    typedef struct packed {
        logic [1:0] master;
        logic [1:0] kind;
        logic [1:0] dir;
        logic [1:0] size;
    } cond_t;
endpackage

// File: rtl/brk_regs.sv
// Module: register file of one break channel. It holds the reference
// address, the address mask, the condition byte and the sticky flag.
// Assumes a single write port. Reads are combinational on reg_sel.
// The hit input comes from the comparator and is computed from the
// values held before this edge, so a write lands after the compare.
module brk_regs
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REG_SEL_W-1:0] sel,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    wdata,
    input  logic                 hit,
    output logic [ADDR_W-1:0]    rdata,
    output logic [ADDR_W-1:0]    ref_addr,
    output logic [ADDR_W-1:0]    ref_mask,
    output cond_t                cond,
    output logic                 flag
);
    logic wr_clear;
    logic unused_wbits;

    assign wr_clear     = we && (sel == SEL_STATUS) && wdata[0];
    assign unused_wbits = ^wdata;

    // Address and mask registers: plain read/write storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_addr <= '0;
            ref_mask <= '0;
        end else if (we) begin
            if (sel == SEL_ADDR) ref_addr <= wdata;
            if (sel == SEL_MASK) ref_mask <= wdata;
        end
    end

    // Condition byte: only the low eight bits are kept.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cond <= '0;
        else if (we && sel == SEL_COND)     cond <= cond_t'(wdata[COND_W-1:0]);
    end

    // Sticky flag: set by a hit, cleared by writing 1; a hit wins.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (hit)      flag <= 1'b1;
        else if (wr_clear) flag <= 1'b0;
    end

    // Read multiplexer with zero fill above each stored field.
    always_comb begin
        rdata = '0;
        case (sel)
            SEL_ADDR:   rdata = ref_addr;
            SEL_MASK:   rdata = ref_mask;
            SEL_COND:   rdata[COND_W-1:0] = cond;
            SEL_STATUS: rdata[0] = flag;
            default:    rdata = '0;
        endcase
    end

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !wr_clear) |=> flag);

    // R9
    clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clear && !hit) |=> !flag);

    // R2
    cond_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_COND) |-> (rdata[ADDR_W-1:COND_W] == '0));

    // R10
    late_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_ADDR) |=> (ref_addr == $past(wdata)));
endmodule

// File: rtl/brk_match.sv
// Module: combinational comparator for one break channel. A bus cycle
// hits when it is valid, the masked address agrees, and the master,
// kind, direction and size fields all accept the cycle.
// Assumes the size field value 00 means any size.
module brk_match
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  bus_attr_t         attr,
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic [ADDR_W-1:0] ref_mask,
    input  cond_t             cond,
    output logic              hit
);
    logic [ADDR_W-1:0] bit_ok;
    logic              addr_ok;
    logic              master_ok;
    logic              kind_ok;
    logic              dir_ok;
    logic              size_ok;

    // Per-bit address agreement, forced true where the mask is set.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign bit_ok[i] = ref_mask[i] || (addr[i] == ref_addr[i]);
    end

    // Field decode: low bit accepts the 0 case, high bit the 1 case.
    always_comb begin
        addr_ok   = &bit_ok;
        master_ok = (cond.master[0] && !attr.is_dma)   || (cond.master[1] && attr.is_dma);
        kind_ok   = (cond.kind[0]   && !attr.is_data)  || (cond.kind[1]   && attr.is_data);
        dir_ok    = (cond.dir[0]    && !attr.is_write) || (cond.dir[1]    && attr.is_write);
        size_ok   = (cond.size == 2'b00) || (cond.size == attr.size);
        hit       = valid && addr_ok && master_ok && kind_ok && dir_ok && size_ok;
    end

    // R4
    master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond.master == 2'b00) |-> !hit);

    // R8
    valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> !hit);

    // R3
    unmasked_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (((addr ^ ref_addr) & ~ref_mask) == '0));
endmodule

// File: rtl/bus_break_channel.sv
// Module: top of one break channel. It joins the register file and the
// comparator. break_irq is the registered sticky flag.
// Assumes monitor inputs are synchronous to clk and valid for one cycle.
module bus_break_channel
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REG_SEL_W-1:0] reg_sel,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_wdata,
    output logic [ADDR_W-1:0]    reg_rdata,
    input  logic                 bus_valid,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_is_dma,
    input  logic                 bus_is_data,
    input  logic                 bus_is_write,
    input  logic [1:0]           bus_size,
    output logic                 break_irq
);
    logic [ADDR_W-1:0] ref_addr;
    logic [ADDR_W-1:0] ref_mask;
    cond_t             cond;
    logic              hit;
    logic              flag;
    bus_attr_t         attr;

    assign attr = '{is_dma: bus_is_dma, is_data: bus_is_data,
                    is_write: bus_is_write, size: bus_size};

    brk_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(reg_sel), .we(reg_we),
        .wdata(reg_wdata), .hit(hit), .rdata(reg_rdata),
        .ref_addr(ref_addr), .ref_mask(ref_mask), .cond(cond), .flag(flag)
    );

    brk_match #(.ADDR_W(ADDR_W)) u_match (
        .clk(clk), .rst_n(rst_n), .valid(bus_valid), .addr(bus_addr),
        .attr(attr), .ref_addr(ref_addr), .ref_mask(ref_mask),
        .cond(cond), .hit(hit)
    );

    assign break_irq = flag;

    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(break_irq) |-> $past(bus_valid));
endmodule

// File: tb/bus_break_channel_tb.sv
module bus_break_channel_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    reg_sel = '0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          bus_valid = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_is_dma = 1'b0;
    logic          bus_is_data = 1'b0;
    logic          bus_is_write = 1'b0;
    logic [1:0]    bus_size = 2'b00;
    logic          break_irq;

    int checks = 0;
    int failures = 0;

    // Reference state of the channel
    logic [AW-1:0] m_addr = '0, m_mask = '0;
    logic [7:0]    m_cond = '0;
    bit            m_flag = 0;

    bus_break_channel #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
        .bus_addr(bus_addr), .bus_is_dma(bus_is_dma), .bus_is_data(bus_is_data),
        .bus_is_write(bus_is_write), .bus_size(bus_size), .break_irq(break_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] model_read(input logic [1:0] s);
        case (s)
            2'd0: return m_addr;
            2'd1: return m_mask;
            2'd2: return {24'h0, m_cond};
            default: return {31'h0, m_flag};
        endcase
    endfunction

    function automatic bit model_hit();
        bit ok;
        if (!bus_valid) return 0;
        ok = ((bus_addr ^ m_addr) & ~m_mask) == 0;
        case (m_cond[7:6])
            2'b00: ok = 0;
            2'b01: ok = ok && !bus_is_dma;
            2'b10: ok = ok && bus_is_dma;
            default: ;
        endcase
        case (m_cond[5:4])
            2'b00: ok = 0;
            2'b01: ok = ok && !bus_is_data;
            2'b10: ok = ok && bus_is_data;
            default: ;
        endcase
        case (m_cond[3:2])
            2'b00: ok = 0;
            2'b01: ok = ok && !bus_is_write;
            2'b10: ok = ok && bus_is_write;
            default: ;
        endcase
        if (m_cond[1:0] != 2'b00 && m_cond[1:0] != bus_size) ok = 0;
        return ok;
    endfunction

    // One clock: drive at the falling edge, compare, advance the model.
    task automatic step(input string req, input bit we, input logic [1:0] sel,
                        input logic [AW-1:0] wd, input bit v, input logic [AW-1:0] a,
                        input bit dma, input bit dat, input bit wr, input logic [1:0] sz);
        bit h;
        @(negedge clk);
        reg_we = we; reg_sel = sel; reg_wdata = wd;
        bus_valid = v; bus_addr = a; bus_is_dma = dma;
        bus_is_data = dat; bus_is_write = wr; bus_size = sz;
        #1;
        check({req, " irq"}, {31'h0, break_irq}, {31'h0, m_flag});
        check({req, " rdata"}, reg_rdata, model_read(sel));
        h = model_hit();
        if (h) m_flag = 1;
        else if (we && sel == 2'd3 && wd[0]) m_flag = 0;
        if (we) case (sel)
            2'd0: m_addr = wd;
            2'd1: m_mask = wd;
            2'd2: m_cond = wd[7:0];
            default: ;
        endcase
        @(posedge clk);
    endtask

    task automatic wr(input string req, input logic [1:0] s, input logic [AW-1:0] d);
        step(req, 1, s, d, 0, '0, 0, 0, 0, 2'b00);
    endtask
    task automatic rd(input string req, input logic [1:0] s);
        step(req, 0, s, '0, 0, '0, 0, 0, 0, 2'b00);
    endtask
    task automatic bus(input string req, input logic [AW-1:0] a, input bit dma,
                       input bit dat, input bit w, input logic [1:0] sz);
        step(req, 0, 2'd3, '0, 1, a, dma, dat, w, sz);
        rd(req, 2'd3);
    endtask
    task automatic clr(input string req);
        wr(req, 2'd3, 32'h1);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        localparam logic [AW-1:0] A = 32'h1234_5678;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 R2 reset values
        for (int s = 0; s < 4; s++) rd("R1_R2 reset", 2'(s));
        // R1 read/write
        wr("R1 addr", 2'd0, 32'hFFFF_FFFF); rd("R1 addr", 2'd0);
        wr("R1 mask", 2'd1, 32'hA5A5_5A5A); rd("R1 mask", 2'd1);
        wr("R1 addr", 2'd0, A);            wr("R1 mask", 2'd1, 32'h0);
        // R2 reserved bits
        wr("R2 cond", 2'd2, 32'hFFFF_FFFF); rd("R2 cond", 2'd2);
        // R4 disabled channel
        wr("R4 off", 2'd2, 32'h3C);
        bus("R4 off", A, 0, 0, 0, 2'b11);
        bus("R4 off", A, 1, 1, 1, 2'b01);
        // R4 CPU only
        wr("R4 cpu", 2'd2, 32'h7C);
        bus("R4 cpu dma", A, 1, 0, 0, 2'b11);
        bus("R4 cpu", A, 0, 0, 0, 2'b11);
        rd("R9 sticky", 2'd3); rd("R9 sticky", 2'd0);
        wr("R9 zero write", 2'd3, 32'h0); rd("R9 zero write", 2'd3);
        clr("R9 clear"); rd("R9 clear", 2'd3);
        // R4 DMA only, then both
        wr("R4 dma", 2'd2, 32'hBC);
        bus("R4 dma cpu", A, 0, 1, 1, 2'b10);
        bus("R4 dma", A, 1, 1, 1, 2'b10); clr("R4");
        wr("R4 both", 2'd2, 32'hFC);
        bus("R4 both", A, 0, 1, 0, 2'b01); clr("R4");
        bus("R4 both", A, 1, 0, 1, 2'b01); clr("R4");
        // R5 kind
        wr("R5 fetch", 2'd2, 32'hDC);
        bus("R5 fetch data", A, 0, 1, 0, 2'b11);
        bus("R5 fetch", A, 0, 0, 0, 2'b11); clr("R5");
        wr("R5 data", 2'd2, 32'hEC);
        bus("R5 data fetch", A, 0, 0, 0, 2'b11);
        bus("R5 data", A, 0, 1, 0, 2'b11); clr("R5");
        wr("R5 none", 2'd2, 32'hCC);
        bus("R5 none", A, 0, 1, 0, 2'b11);
        // R6 direction
        wr("R6 read", 2'd2, 32'hF4);
        bus("R6 read wr", A, 0, 1, 1, 2'b11);
        bus("R6 read", A, 0, 1, 0, 2'b11); clr("R6");
        wr("R6 write", 2'd2, 32'hF8);
        bus("R6 write rd", A, 0, 1, 0, 2'b11);
        bus("R6 write", A, 0, 1, 1, 2'b11); clr("R6");
        wr("R6 none", 2'd2, 32'hF0);
        bus("R6 none", A, 0, 1, 1, 2'b11);
        // R7 size
        for (int f = 0; f < 4; f++) begin
            wr("R7 size", 2'd2, 32'hFC | f);
            for (int z = 1; z < 4; z++) begin
                bus("R7 size", A, 0, 1, 0, 2'(z)); clr("R7");
            end
        end
        // R3 masking
        wr("R3", 2'd2, 32'hFC);
        bus("R3 unmasked low", A ^ 32'h1, 0, 1, 0, 2'b11);
        wr("R3", 2'd1, 32'h0000_000F);
        bus("R3 masked low", A ^ 32'h9, 0, 1, 0, 2'b11); clr("R3");
        bus("R3 bit31", A ^ 32'h8000_0000, 0, 1, 0, 2'b11);
        wr("R3", 2'd1, 32'hFFFF_FFFF);
        bus("R3 all masked", ~A, 1, 0, 1, 2'b01); clr("R3");
        wr("R3", 2'd1, 32'h0);
        // R8 valid gating
        step("R8 no valid", 0, 2'd3, '0, 0, A, 0, 1, 0, 2'b11);
        rd("R8 no valid", 2'd3);
        // R10 write during bus cycle
        step("R10 old cond", 1, 2'd2, 32'h0, 1, A, 0, 1, 0, 2'b11);
        rd("R10 old cond", 2'd3); clr("R10");
        bus("R10 new cond", A, 0, 1, 0, 2'b11);
        wr("R10", 2'd2, 32'hFC);
        step("R10 old addr", 1, 2'd0, 32'h0, 1, A, 0, 1, 0, 2'b11);
        rd("R10 old addr", 2'd3); clr("R10");
        bus("R10 new addr", A, 0, 1, 0, 2'b11);
        // R9 set wins over clear
        bus("R9 set", 32'h0, 0, 1, 0, 2'b11);
        step("R9 set wins", 1, 2'd3, 32'h1, 1, 32'h0, 0, 1, 0, 2'b11);
        rd("R9 set wins", 2'd3); rd("R9 set wins", 2'd3);
        clr("R9"); rd("R9", 2'd3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule